// File: doc/BRIEF.md
# Sensor fault status latch

This block supervises the health of a sensor front end and reports it on a single status line. It watches three fault sources: a low-supply flag, the frequency of an internal oscillator, and the parity of a bank of trim bits. Any of these sets a sticky fault latch. The status output is the latch ORed with the live self-test input, so driving self-test high also confirms that the self-test and status wiring both work.

The latch is cleared only by a self-test pulse that stays high for at least a set number of reference-clock cycles. A clear is refused while any fault is still present. After power-on reset the status line is not meaningful until the first qualified self-test pulse, and a separate valid flag reports this. All logic runs on one reference clock. The oscillator under test, the self-test input and the low-supply flag are each brought in through two-flop synchronizers.

The frequency check counts rising edges of the monitored oscillator over a fixed gate of reference cycles. The default limits fit a 16 MHz reference with a 100 µs gate, which places the pass window between 50 kHz and 260 kHz.

Top module: `fault_supervisor`

## Requirements
- R1: While `rst_n` is low, and after its release until a fault or self-test occurs, `status_o` and `valid_o` are both 0.
- R2: `status_o` is 1 from the third rising `clk_ref` edge after `st_in` goes high, for as long as `st_in` stays high, whatever the state of the latch.
- R3: `lvd_in` held high for at least three reference cycles sets the latch. `status_o` then stays 1 after `lvd_in` falls, until a qualified clear.
- R4: An odd number of ones in `trim_bits` (XOR reduction equal to 1) is a fault and sets the latch. An even count is no fault.
- R5: The monitor counts rising edges of `osc_in` in each window of `GATE_CYCLES` reference cycles. A count below `EDGE_MIN` or above `EDGE_MAX` sets the latch. A stopped oscillator counts as too slow.
- R6: A self-test high time shorter than `QUAL_CYCLES` reference cycles does not clear the latch. A high time of `QUAL_CYCLES` or more clears it, and `status_o` then reads 0 once `st_in` is low again.
- R7: While any fault source is still active, a qualified self-test pulse leaves the latch set. A set and a clear in the same cycle resolve to set.
- R8: `valid_o` stays 0 after reset until the first qualified self-test pulse, and then stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock for all logic |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| osc_in | input | 1 | Monitored oscillator, sampled in the reference domain |
| lvd_in | input | 1 | Low-supply detect flag, asynchronous |
| st_in | input | 1 | Self-test request, asynchronous |
| trim_bits | input | TRIM_W | Trim bit bank checked for parity |
| status_o | output | 1 | Registered fault latch OR self-test |
| valid_o | output | 1 | High once the first qualified self-test pulse has been seen |

## Verification
The bench builds the block with an 8-bit trim bank, a 64-cycle gate, an edge window of 5 to 12, and a 20-cycle qualification width. These small values let full gate windows run many times. They also make the one-cycle boundary between a 19-cycle and a 20-cycle self-test pulse cheap to exercise. With the bench oscillator toggling every 2, 4 or 10 reference cycles, the window sees 16, 8 or about 3 edges. This drives the too-fast, in-range and too-slow cases, and a stopped oscillator gives the zero-edge case.

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int TRIM_W      = 16,
  parameter int GATE_CYCLES = 1600,
  parameter int EDGE_MIN    = 5,
  parameter int EDGE_MAX    = 26,
  parameter int QUAL_CYCLES = 1600
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              osc_in,
  input  logic              lvd_in,
  input  logic              st_in,
  input  logic [TRIM_W-1:0] trim_bits,
  output logic              status_o,
  output logic              valid_o
);

  localparam int GW = $clog2(GATE_CYCLES);
  localparam int EW = $clog2(GATE_CYCLES + 1);
  localparam int QW = $clog2(QUAL_CYCLES + 1);
  localparam logic [GW-1:0] GATE_LAST = GW'(GATE_CYCLES - 1);
  localparam logic [EW-1:0] LO_LIM    = EW'(EDGE_MIN);
  localparam logic [EW-1:0] HI_LIM    = EW'(EDGE_MAX);
  localparam logic [QW-1:0] QUAL_LAST = QW'(QUAL_CYCLES - 1);
  localparam logic [QW-1:0] QUAL_FULL = QW'(QUAL_CYCLES);

  // two-flop synchronizers
  logic [1:0] st_ff, lvd_ff, osc_ff;
  logic       osc_prev;
  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) begin
      st_ff    <= '0;
      lvd_ff   <= '0;
      osc_ff   <= '0;
      osc_prev <= 1'b0;
    end else begin
      st_ff    <= {st_ff[0], st_in};
      lvd_ff   <= {lvd_ff[0], lvd_in};
      osc_ff   <= {osc_ff[0], osc_in};
      osc_prev <= osc_ff[1];
    end

  wire st_sync  = st_ff[1];
  wire lvd_sync = lvd_ff[1];
  wire osc_rise = osc_ff[1] & ~osc_prev;

  // trim parity
  logic par_q;
  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) par_q <= 1'b0;
    else        par_q <= ^trim_bits;

  // frequency window
  logic [GW-1:0] gate_cnt;
  logic [EW-1:0] edge_cnt;
  logic          clk_bad;
  wire  [EW-1:0] edges_now = edge_cnt + EW'(osc_rise);

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) begin
      gate_cnt <= '0;
      edge_cnt <= '0;
      clk_bad  <= 1'b0;
    end else if (gate_cnt == GATE_LAST) begin
      gate_cnt <= '0;
      edge_cnt <= '0;
      clk_bad  <= (edges_now < LO_LIM) || (edges_now > HI_LIM);
    end else begin
      gate_cnt <= gate_cnt + GW'(1);
      edge_cnt <= edges_now;
    end

  // self-test width qualification
  logic [QW-1:0] st_run;
  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n)                  st_run <= '0;
    else if (!st_sync)           st_run <= '0;
    else if (st_run != QUAL_FULL) st_run <= st_run + QW'(1);

  wire qual_hit  = st_sync && (st_run == QUAL_LAST);
  wire fault_now = lvd_sync | clk_bad | par_q;

  // fault latch, valid flag, status
  logic latch_q;
  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) begin
      latch_q  <= 1'b0;
      valid_o  <= 1'b0;
      status_o <= 1'b0;
    end else begin
      if (fault_now)     latch_q <= 1'b1;
      else if (qual_hit) latch_q <= 1'b0;
      if (qual_hit)      valid_o <= 1'b1;
      status_o <= latch_q | st_sync;
    end

  a_r1_reset_quiet: assert property (@(posedge clk_ref)
    !rst_n |-> (!status_o && !valid_o));

  a_r2_selftest_loopback: assert property (@(posedge clk_ref) disable iff (!rst_n)
    st_sync |=> status_o);

  a_r3_latch_sticky: assert property (@(posedge clk_ref) disable iff (!rst_n)
    latch_q && !qual_hit |=> latch_q);

  a_r3_lvd_sets: assert property (@(posedge clk_ref) disable iff (!rst_n)
    lvd_sync |=> latch_q);

  a_r4_parity_sets: assert property (@(posedge clk_ref) disable iff (!rst_n)
    par_q |=> latch_q);

  a_r5_clock_sets: assert property (@(posedge clk_ref) disable iff (!rst_n)
    clk_bad |=> latch_q);

  a_r6_clear_needs_width: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(latch_q) |-> ($past(st_sync) && $past(st_run) == QUAL_LAST));

  a_r7_fault_blocks_clear: assert property (@(posedge clk_ref) disable iff (!rst_n)
    fault_now |=> latch_q);

  a_r8_valid_holds: assert property (@(posedge clk_ref) disable iff (!rst_n)
    valid_o |=> valid_o);

  a_r8_valid_waits: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !valid_o && !qual_hit |=> !valid_o);

endmodule

// File: tb/test_fault_supervisor.sv
`timescale 1ns/1ps
module test_fault_supervisor;

  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc = 1'b0;
  logic lvd = 1'b0;
  logic st = 1'b0;
  logic [TW-1:0] trim = '0;
  logic status_o, valid_o;

  int osc_half = 4;
  bit osc_run = 1'b1;
  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  typedef struct {
    string req;
    bit    st;
    bit    vl;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  fault_supervisor #(
    .TRIM_W(TW), .GATE_CYCLES(64), .EDGE_MIN(5), .EDGE_MAX(12), .QUAL_CYCLES(20)
  ) i_fault_supervisor (
    .clk_ref(clk), .rst_n(rst_n), .osc_in(osc), .lvd_in(lvd), .st_in(st),
    .trim_bits(trim), .status_o(status_o), .valid_o(valid_o)
  );

  initial forever begin
    repeat (osc_half) @(negedge clk);
    if (osc_run) osc = ~osc;
  end

  initial forever begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      nvec++;
      if (status_o !== e.st || valid_o !== e.vl) begin
        nfail++;
        $display("FAIL %s: status=%b valid=%b, expected status=%b valid=%b",
                 e.req, status_o, valid_o, e.st, e.vl);
      end
    end
  end

  task automatic expect_out(input string r, input bit s, input bit v);
    q.push_back('{r, s, v});
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    st = 1'b1;
    wait_cyc(n);
    st = 1'b0;
    wait_cyc(6);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    wait_cyc(5);
    expect_out("R1 in reset", 1'b0, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(200);
    expect_out("R1 idle after reset", 1'b0, 1'b0);

    // loopback with clear latch
    @(negedge clk) st = 1'b1;
    wait_cyc(3);
    expect_out("R2 loopback at third edge", 1'b1, 1'b0);
    wait_cyc(5);
    expect_out("R2 loopback held", 1'b1, 1'b0);
    st = 1'b0;
    wait_cyc(6);
    expect_out("R8 short pulse leaves invalid", 1'b0, 1'b0);

    pulse(19);
    expect_out("R8 19-cycle pulse not qualified", 1'b0, 1'b0);
    pulse(20);
    expect_out("R8 20-cycle pulse validates", 1'b0, 1'b1);

    // low supply
    @(negedge clk) lvd = 1'b1;
    wait_cyc(4);
    lvd = 1'b0;
    wait_cyc(6);
    expect_out("R3 lvd sets latch", 1'b1, 1'b1);
    wait_cyc(100);
    expect_out("R3 latch sticky", 1'b1, 1'b1);

    @(negedge clk) st = 1'b1;
    wait_cyc(3);
    expect_out("R2 loopback with latch set", 1'b1, 1'b1);
    wait_cyc(7);
    st = 1'b0;
    wait_cyc(6);
    expect_out("R6 10-cycle pulse no clear", 1'b1, 1'b1);
    pulse(19);
    expect_out("R6 19-cycle pulse no clear", 1'b1, 1'b1);
    pulse(20);
    expect_out("R6 20-cycle pulse clears", 1'b0, 1'b1);

    // parity
    @(negedge clk) trim = 8'h01;
    wait_cyc(6);
    expect_out("R4 odd parity 01 sets", 1'b1, 1'b1);
    pulse(25);
    expect_out("R7 clear blocked by parity", 1'b1, 1'b1);
    @(negedge clk) trim = 8'h03;
    wait_cyc(6);
    expect_out("R4 even parity keeps latch", 1'b1, 1'b1);
    pulse(25);
    expect_out("R4 even parity allows clear", 1'b0, 1'b1);
    @(negedge clk) trim = 8'hFE;
    wait_cyc(6);
    expect_out("R4 odd parity FE sets", 1'b1, 1'b1);
    @(negedge clk) trim = 8'hF0;
    pulse(25);
    expect_out("R4 clear after even F0", 1'b0, 1'b1);

    // persistent lvd blocks clear
    @(negedge clk) lvd = 1'b1;
    wait_cyc(6);
    pulse(25);
    expect_out("R7 clear blocked by lvd", 1'b1, 1'b1);
    @(negedge clk) lvd = 1'b0;
    wait_cyc(6);
    pulse(25);
    expect_out("R7 clear once lvd gone", 1'b0, 1'b1);

    // oscillator window
    osc_half = 10;
    wait_cyc(200);
    expect_out("R5 slow oscillator", 1'b1, 1'b1);
    osc_half = 4;
    wait_cyc(200);
    pulse(25);
    expect_out("R5 nominal then clear", 1'b0, 1'b1);
    osc_half = 2;
    wait_cyc(200);
    expect_out("R5 fast oscillator", 1'b1, 1'b1);
    osc_half = 4;
    wait_cyc(200);
    pulse(25);
    expect_out("R5 nominal then clear", 1'b0, 1'b1);
    osc_run = 1'b0;
    wait_cyc(200);
    expect_out("R5 stopped oscillator", 1'b1, 1'b1);
    osc_run = 1'b1;
    wait_cyc(200);
    pulse(25);
    expect_out("R5 restart then clear", 1'b0, 1'b1);

    @(negedge clk) rst_n = 1'b0;
    wait_cyc(2);
    expect_out("R1 reset drops valid", 1'b0, 1'b0);
    wait_cyc(3);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog R1-independent timeout: actual=running expected=finished");
      finish_run();
    end
  end

endmodule